// File: doc/BRIEF.md
# Two-Stage Branch Direction Predictor

This block gives a branch two predictions at two points of the front end. During fetch, a small two-way set-associative target buffer is searched with the fetch address. A hit is an early guess that the branch is taken, and it supplies the target. One stage later, at decode, a direct-mapped table of 2-bit saturating counters gives the direction that the pipeline actually follows. If the counter table disagrees with the early guess that came down the pipe with the instruction, the block raises a one-cycle redirect that carries the corrected next address.

The block also limits speculation. It counts predicted branches that are still unresolved and holds decode when the count reaches the cap. When a branch resolves, its actual outcome trains the counter and allocates, refreshes or invalidates the matching target-buffer entry. A mispredicted resolution empties the count, because the pipeline flushes every younger branch.

Top module: `brpred_two_stage`

## Requirements
- R1: With `f_valid` high, `f_pred_taken` is high in the same cycle exactly when one way of set `f_pc[8:2]` is valid and holds tag `f_pc[31:9]`. `f_pred_target` is then that way's stored target. With `f_valid` low, `f_pred_taken` is low.
- R2: `d_pred_taken` comes combinationally from the counter at index `d_pc[12:2]` and is high when that counter is 2 or 3. After reset every counter is 1, so an untrained branch is predicted not taken.
- R3: A resolution (`r_valid`) moves the counter at `r_pc[12:2]` one step toward the outcome `r_taken`, saturating at 0 and 3, starting from the next clock. A counter at 3 therefore still predicts taken after one not-taken outcome.
- R4: A taken resolution writes tag and `r_target` into the set. It uses the way that already holds the tag; otherwise the first invalid way, way 0 before way 1; otherwise the least recently written way. The way written becomes the most recently used.
- R5: A not-taken resolution clears the valid bit of a matching entry, so later fetch lookups of that address miss. A not-taken resolution that finds no matching entry changes nothing.
- R6: An accepted decode whose `d_pred_taken` differs from `d_early_taken` raises `redirect_valid` for exactly one cycle, in the next cycle. `redirect_pc` is `d_br_target` when the counter says taken and `d_pc + 4` when it says not taken.
- R7: With `d_valid` high and `spec_count` equal to `MAX_SPEC` (default 4), `d_stall` is high. A stalled branch is not counted and raises no redirect.
- R8: `spec_count` rises by one for each accepted decode. It falls by one for each correct resolution (`r_mispredict` low), but never below zero. A mispredicted resolution sets it to 0 and cancels any redirect from the same cycle's decode.
- R9: Reset leaves every target-buffer way invalid, `spec_count` at 0 and `redirect_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_valid | input | 1 | Fetch lookup valid |
| f_pc | input | PC_W | Fetch address |
| f_pred_taken | output | 1 | Early guess: target buffer hit |
| f_pred_target | output | PC_W | Target from the hit way |
| d_valid | input | 1 | A branch is at decode |
| d_pc | input | PC_W | Address of the decoded branch |
| d_early_taken | input | 1 | Early guess carried with the branch |
| d_br_target | input | PC_W | Branch target computed at decode |
| d_pred_taken | output | 1 | Counter-table direction |
| d_stall | output | 1 | Decode must hold: speculation cap reached |
| redirect_valid | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | PC_W | Corrected next address |
| r_valid | input | 1 | Branch resolution valid |
| r_pc | input | PC_W | Address of the resolved branch |
| r_taken | input | 1 | Actual outcome |
| r_target | input | PC_W | Actual target |
| r_mispredict | input | 1 | Resolution found a misprediction |
| spec_count | output | CNT_W | Unresolved predicted branches |

## Verification
The bench aims at addresses that share a set and trains three tags into two ways, so a wrong victim choice or a recency bit that is not refreshed shows up as a fetch miss or a wrong target. It drives counters into saturation and back by one step; a counter that wraps, or one that loses its hysteresis, flips `d_pred_taken` too early. It fills the speculation cap without resolving, then mixes decodes with correct and mispredicted resolutions in the same cycle. An off-by-one in the cap lets a fifth branch through. A missing clear leaves the count stale. A redirect that is not cancelled by a flush appears one cycle after the mispredict.

// File: rtl/brpred_pkg.sv
package brpred_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_INIT = 2'd1;

  function automatic ctr2_t ctr_step(ctr2_t cur, logic up);
    ctr2_t nxt;
    nxt = cur;
    if (up && cur != 2'd3) nxt = cur + 2'd1;
    else if (!up && cur != 2'd0) nxt = cur - 2'd1;
    return nxt;
  endfunction

  function automatic logic ctr_says_taken(ctr2_t cur);
    return cur[1];
  endfunction
endpackage

// File: rtl/brpred_dir_table.sv
module brpred_dir_table
  import brpred_pkg::*;
#(
  parameter int ENTRIES = 2048,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  ctr2_t cnt_q [ENTRIES];
  ctr2_t wr_val_d;

  always_comb begin
    wr_val_d = ctr_step(cnt_q[wr_idx], wr_taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) cnt_q[i] <= CTR_INIT;
    end else if (wr_en) begin
      cnt_q[wr_idx] <= wr_val_d;
    end
  end

  assign rd_taken = ctr_says_taken(cnt_q[rd_idx]);
endmodule

// File: rtl/brpred_tgt_buf.sv
module brpred_tgt_buf #(
  parameter int PC_W = 32,
  parameter int SETS = 128,
  localparam int WAYS  = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = PC_W - 2 - SET_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic [PC_W-1:0] lk_target,
  input  logic            up_en,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [PC_W-1:0] up_target
);
  logic [WAYS-1:0]  vld_q [SETS];
  logic             lru_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PC_W-1:0]  tgt_q [SETS][WAYS];

  logic [SET_W-1:0] lk_set, up_set;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic [WAYS-1:0]  lk_match, up_match;

  assign lk_set = lk_pc[2 +: SET_W];
  assign lk_tag = lk_pc[PC_W-1 -: TAG_W];
  assign up_set = up_pc[2 +: SET_W];
  assign up_tag = up_pc[PC_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way_cmp
    assign lk_match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    assign up_match[w] = vld_q[up_set][w] && (tag_q[up_set][w] == up_tag);
  end

  assign lk_hit    = lk_valid && (|lk_match);
  assign lk_target = lk_match[1] ? tgt_q[lk_set][1] : tgt_q[lk_set][0];

  logic fill_way_d;
  logic fill_en_d;
  logic kill_en_d;
  logic kill_way_d;

  always_comb begin
    if (up_match[0])             fill_way_d = 1'b0;
    else if (up_match[1])        fill_way_d = 1'b1;
    else if (!vld_q[up_set][0])  fill_way_d = 1'b0;
    else if (!vld_q[up_set][1])  fill_way_d = 1'b1;
    else                         fill_way_d = lru_q[up_set];
    fill_en_d  = up_en && up_taken;
    kill_en_d  = up_en && !up_taken && (|up_match);
    kill_way_d = up_match[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        lru_q[s] <= 1'b0;
      end
    end else if (fill_en_d) begin
      vld_q[up_set][fill_way_d] <= 1'b1;
      lru_q[up_set]             <= ~fill_way_d;
    end else if (kill_en_d) begin
      vld_q[up_set][kill_way_d] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en_d) begin
      tag_q[up_set][fill_way_d] <= up_tag;
      tgt_q[up_set][fill_way_d] <= up_target;
    end
  end
endmodule

// File: rtl/brpred_spec_ctr.sv
module brpred_spec_ctr #(
  parameter int MAX_SPEC = 4,
  localparam int CNT_W = $clog2(MAX_SPEC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dec_ok;

  assign dec_ok = dec && (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) cnt_d = '0;
    else if (inc && !dec_ok) cnt_d = cnt_q + 1'b1;
    else if (!inc && dec_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
  assign full  = (cnt_q == CNT_W'(MAX_SPEC));
endmodule

// File: rtl/brpred_two_stage.sv
module brpred_two_stage #(
  parameter int PC_W        = 32,
  parameter int BTB_SETS    = 128,
  parameter int BHT_ENTRIES = 2048,
  parameter int MAX_SPEC    = 4,
  localparam int BHT_IDX_W  = $clog2(BHT_ENTRIES),
  localparam int CNT_W      = $clog2(MAX_SPEC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             f_valid,
  input  logic [PC_W-1:0]  f_pc,
  output logic             f_pred_taken,
  output logic [PC_W-1:0]  f_pred_target,
  input  logic             d_valid,
  input  logic [PC_W-1:0]  d_pc,
  input  logic             d_early_taken,
  input  logic [PC_W-1:0]  d_br_target,
  output logic             d_pred_taken,
  output logic             d_stall,
  output logic             redirect_valid,
  output logic [PC_W-1:0]  redirect_pc,
  input  logic             r_valid,
  input  logic [PC_W-1:0]  r_pc,
  input  logic             r_taken,
  input  logic [PC_W-1:0]  r_target,
  input  logic             r_mispredict,
  output logic [CNT_W-1:0] spec_count
);
  // Reset: asserted at once, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_q = rst_pipe_q[1];

  brpred_tgt_buf #(.PC_W(PC_W), .SETS(BTB_SETS)) u_tgt_buf (
    .clk       (clk),
    .rst_n     (rst_n_q),
    .lk_valid  (f_valid),
    .lk_pc     (f_pc),
    .lk_hit    (f_pred_taken),
    .lk_target (f_pred_target),
    .up_en     (r_valid),
    .up_pc     (r_pc),
    .up_taken  (r_taken),
    .up_target (r_target)
  );

  brpred_dir_table #(.ENTRIES(BHT_ENTRIES)) u_dir_table (
    .clk      (clk),
    .rst_n    (rst_n_q),
    .rd_idx   (d_pc[2 +: BHT_IDX_W]),
    .rd_taken (d_pred_taken),
    .wr_en    (r_valid),
    .wr_idx   (r_pc[2 +: BHT_IDX_W]),
    .wr_taken (r_taken)
  );

  logic cap_full;
  logic dec_accept;
  logic flush_now;

  assign flush_now  = r_valid && r_mispredict;
  assign d_stall    = d_valid && cap_full;
  assign dec_accept = d_valid && !cap_full;

  brpred_spec_ctr #(.MAX_SPEC(MAX_SPEC)) u_spec_ctr (
    .clk   (clk),
    .rst_n (rst_n_q),
    .inc   (dec_accept),
    .dec   (r_valid && !r_mispredict),
    .clr   (flush_now),
    .count (spec_count),
    .full  (cap_full)
  );

  // Override: the counter table wins over the early guess.
  logic            rdr_vld_q, rdr_vld_d;
  logic [PC_W-1:0] rdr_pc_q,  rdr_pc_d;
  logic            rdr_load;

  always_comb begin
    rdr_vld_d = dec_accept && !flush_now && (d_pred_taken != d_early_taken);
    rdr_pc_d  = d_pred_taken ? d_br_target : (d_pc + PC_W'(4));
    rdr_load  = rdr_vld_d;
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) rdr_vld_q <= 1'b0;
    else          rdr_vld_q <= rdr_vld_d;
  end

  always_ff @(posedge clk) begin
    if (rdr_load) rdr_pc_q <= rdr_pc_d;
  end

  assign redirect_valid = rdr_vld_q;
  assign redirect_pc    = rdr_pc_q;
endmodule

// File: rtl/brpred_two_stage_chk.sv
module brpred_two_stage_chk #(
  parameter int PC_W     = 32,
  parameter int MAX_SPEC = 4,
  parameter int CNT_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             f_valid,
  input logic             f_pred_taken,
  input logic             d_valid,
  input logic [PC_W-1:0]  d_pc,
  input logic             d_early_taken,
  input logic             d_pred_taken,
  input logic             d_stall,
  input logic             redirect_valid,
  input logic [PC_W-1:0]  redirect_pc,
  input logic             r_valid,
  input logic             r_mispredict,
  input logic [CNT_W-1:0] spec_count
);
  a_r1_no_lookup_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !f_valid |-> !f_pred_taken);

  a_r7_stall_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && spec_count == CNT_W'(MAX_SPEC)) |-> d_stall);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    spec_count <= CNT_W'(MAX_SPEC));

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && r_mispredict) |=> (spec_count == '0));

  a_r8_flush_blocks_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && r_mispredict) |=> !redirect_valid);

  a_r6_redirect_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && !d_stall && !(r_valid && r_mispredict) && (d_pred_taken != d_early_taken))
      |=> redirect_valid);

  a_r6_fallthrough_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && !d_stall && !(r_valid && r_mispredict) && !d_pred_taken && d_early_taken)
      |=> (redirect_pc == $past(d_pc) + PC_W'(4)));

  a_r7_stall_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (d_stall && !(r_valid && r_mispredict)) |=> (redirect_valid == 1'b0));
endmodule

bind brpred_two_stage brpred_two_stage_chk #(
  .PC_W(PC_W), .MAX_SPEC(MAX_SPEC), .CNT_W(CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n_q),
  .f_valid        (f_valid),
  .f_pred_taken   (f_pred_taken),
  .d_valid        (d_valid),
  .d_pc           (d_pc),
  .d_early_taken  (d_early_taken),
  .d_pred_taken   (d_pred_taken),
  .d_stall        (d_stall),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .r_valid        (r_valid),
  .r_mispredict   (r_mispredict),
  .spec_count     (spec_count)
);

// File: tb/brpred_two_stage_tb_top.sv
`timescale 1ns/1ps
module brpred_two_stage_tb_top;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            f_valid, d_valid, d_early_taken, r_valid, r_taken, r_mispredict;
  logic [PC_W-1:0] f_pc, d_pc, d_br_target, r_pc, r_target;
  logic            f_pred_taken, d_pred_taken, d_stall, redirect_valid;
  logic [PC_W-1:0] f_pred_target, redirect_pc;
  logic [2:0]      spec_count;

  always #5 clk = ~clk;

  brpred_two_stage dut_i (
    .clk(clk), .rst_n(rst_n),
    .f_valid(f_valid), .f_pc(f_pc), .f_pred_taken(f_pred_taken), .f_pred_target(f_pred_target),
    .d_valid(d_valid), .d_pc(d_pc), .d_early_taken(d_early_taken), .d_br_target(d_br_target),
    .d_pred_taken(d_pred_taken), .d_stall(d_stall),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .r_valid(r_valid), .r_pc(r_pc), .r_taken(r_taken), .r_target(r_target),
    .r_mispredict(r_mispredict), .spec_count(spec_count)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Reference state
  int         m_ctr [2048];
  bit         m_vld [128][2];
  bit [22:0]  m_tag [128][2];
  bit [31:0]  m_tgt [128][2];
  bit         m_lru [128];
  int         m_cnt;
  bit         m_rv;
  bit [31:0]  m_rpc;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_lookup(input bit [31:0] pc, output bit [31:0] tgt, output int way);
    int s = int'(pc[8:2]);
    for (int w = 0; w < 2; w++) begin
      if (m_vld[s][w] && m_tag[s][w] == pc[31:9]) begin
        tgt = m_tgt[s][w];
        way = w;
        return 1'b1;
      end
    end
    tgt = '0;
    way = 0;
    return 1'b0;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 2048; i++) m_ctr[i] = 1;
    for (int s = 0; s < 128; s++) begin
      m_vld[s][0] = 0; m_vld[s][1] = 0; m_lru[s] = 0;
    end
    m_cnt = 0; m_rv = 0; m_rpc = '0;
  endtask

  // Drive one cycle at the falling edge, check, advance the reference.
  task automatic step(input bit fv, input bit [31:0] fpc,
                      input bit dv, input bit [31:0] dpc, input bit de, input bit [31:0] dtg,
                      input bit rv, input bit [31:0] rpc, input bit rt, input bit [31:0] rtg,
                      input bit rm);
    bit [31:0] etgt; int eway; bit ehit; bit edir; bit estall; bit acc;
    f_valid = fv; f_pc = fpc;
    d_valid = dv; d_pc = dpc; d_early_taken = de; d_br_target = dtg;
    r_valid = rv; r_pc = rpc; r_taken = rt; r_target = rtg; r_mispredict = rm;
    #1;
    ehit = m_lookup(fpc, etgt, eway) && fv;
    check(f_pred_taken == ehit, "R1 fetch hit", 32'(f_pred_taken), 32'(ehit));
    if (ehit) check(f_pred_target == etgt, "R1 fetch target", f_pred_target, etgt);
    edir = m_ctr[dpc[12:2]] >= 2;
    if (dv) check(d_pred_taken == edir, "R2/R3 counter direction", 32'(d_pred_taken), 32'(edir));
    estall = dv && (m_cnt == 4);
    check(d_stall == estall, "R7 stall", 32'(d_stall), 32'(estall));
    check(redirect_valid == m_rv, "R6/R8 redirect valid", 32'(redirect_valid), 32'(m_rv));
    if (m_rv) check(redirect_pc == m_rpc, "R6 redirect pc", redirect_pc, m_rpc);
    check(int'(spec_count) == m_cnt, "R8 spec count", 32'(spec_count), 32'(m_cnt));
    // next-state of the reference
    acc  = dv && !estall;
    m_rv = acc && !(rv && rm) && (edir != de);
    if (m_rv) m_rpc = edir ? dtg : dpc + 32'd4;
    if (rv && rm) m_cnt = 0;
    else begin
      if (acc) m_cnt++;
      if (rv && (m_cnt - (acc ? 1 : 0)) > 0) m_cnt--;
    end
    if (rv) begin
      int s = int'(rpc[8:2]);
      int idx = int'(rpc[12:2]);
      bit [31:0] t; int w; bit h;
      if (rt && m_ctr[idx] < 3) m_ctr[idx]++;
      if (!rt && m_ctr[idx] > 0) m_ctr[idx]--;
      h = m_lookup(rpc, t, w);
      if (rt) begin
        int v;
        if (h) v = w;
        else if (!m_vld[s][0]) v = 0;
        else if (!m_vld[s][1]) v = 1;
        else v = int'(m_lru[s]);
        m_vld[s][v] = 1; m_tag[s][v] = rpc[31:9]; m_tgt[s][v] = rtg;
        m_lru[s] = (v == 0);
      end else if (h) m_vld[s][w] = 0;
    end
    @(negedge clk);
  endtask

  function automatic bit [31:0] mk_pc(input int si, input int ti);
    bit [6:0]  sets [4] = '{7'd3, 7'd4, 7'd100, 7'd127};
    bit [22:0] tags [4] = '{23'd1, 23'd2, 23'd3, 23'h7fffff};
    return {tags[ti], sets[si], 2'b00};
  endfunction

  task automatic idle();
    step(0, '0, 0, '0, 0, '0, 0, '0, 0, '0, 0);
  endtask

  initial begin : watchdog
    #(150000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    bit [31:0] a, b, c;
    void'($urandom(32'd1234));
    m_reset();
    f_valid = 0; d_valid = 0; r_valid = 0; r_taken = 0; r_mispredict = 0; d_early_taken = 0;
    f_pc = '0; d_pc = '0; d_br_target = '0; r_pc = '0; r_target = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R9: reset state seen at the ports
    f_valid = 1; f_pc = mk_pc(0, 0); #1;
    check(f_pred_taken == 0, "R9 no hit in reset", 32'(f_pred_taken), 0);
    check(spec_count == 0, "R9 count in reset", 32'(spec_count), 0);
    check(redirect_valid == 0, "R9 no redirect in reset", 32'(redirect_valid), 0);
    @(negedge clk);
    rst_n = 1;
    repeat (3) idle();

    a = mk_pc(0, 0); b = mk_pc(0, 1); c = mk_pc(0, 2);
    // R2: untrained, early says taken -> fall-through redirect (R6)
    step(0, '0, 1, a, 1, 32'h1000, 0, '0, 0, '0, 0);
    idle();
    // R3: saturate upward, then one not-taken keeps taken
    repeat (4) step(0, '0, 0, '0, 0, '0, 1, a, 1, 32'h2000, 0);
    step(1, a, 1, a, 0, 32'h2000, 1, a, 0, 32'h2000, 0);
    step(1, a, 1, a, 0, 32'h2000, 0, '0, 0, '0, 0);
    // R4: three tags in one set, LRU eviction
    step(0, '0, 0, '0, 0, '0, 1, b, 1, 32'h3000, 0);
    step(1, a, 0, '0, 0, '0, 1, a, 1, 32'h2004, 0);
    step(1, b, 0, '0, 0, '0, 1, c, 1, 32'h4000, 0);
    step(1, a, 0, '0, 0, '0, 0, '0, 0, '0, 0);
    step(1, c, 0, '0, 0, '0, 0, '0, 0, '0, 0);
    // R5: not-taken invalidates
    step(0, '0, 0, '0, 0, '0, 1, c, 0, 32'h4000, 1);
    step(1, c, 0, '0, 0, '0, 0, '0, 0, '0, 0);
    // R7: fill the cap, fifth stalls
    repeat (6) step(0, '0, 1, mk_pc(1, 1), 0, 32'h5000, 0, '0, 0, '0, 0);
    // R8: correct resolution and decode in same cycle, then mispredict with decode
    step(0, '0, 1, mk_pc(1, 1), 1, 32'h5000, 1, mk_pc(1, 1), 0, '0, 0);
    step(0, '0, 1, mk_pc(2, 0), 1, 32'h6000, 1, mk_pc(2, 0), 0, '0, 1);
    idle();

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      bit rv = ($urandom % 100) < 40;
      step($urandom % 2, mk_pc($urandom % 4, $urandom % 4),
           ($urandom % 100) < 55, mk_pc($urandom % 4, $urandom % 4), $urandom % 2, $urandom,
           rv, mk_pc($urandom % 4, $urandom % 4), $urandom % 2, $urandom,
           rv && (($urandom % 100) < 15));
    end
    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule